// File: doc/BRIEF.md
# Multi-Channel Phase-Offset PWM Generator

This block drives up to four independent pulse-width-modulated outputs from one clock. Every channel is described by three counts of clock cycles: a period, a high time and a start delay. Software sets these through a small register bus that completes each access in one cycle. Writes go to a staged copy of the channel settings. A commit strobe then moves every staged value into the working copy in the same clock edge, so a change to several channels, or to several fields of one channel, appears at the outputs all at once.

A control register holds two bits. A hold bit, set out of reset, freezes every channel and forces all outputs low. A self-clearing commit bit makes the transfer. The register space also has read-only version, identity and signature words set by parameters, a free scratch word for testing bus access, and a word giving the number of channels built.

Each channel runs a three-state machine. HALT is entered whenever hold is set. HALT goes to WAIT when hold clears. Any state other than HALT goes to WAIT on a commit. WAIT counts up to the start delay and then goes to RUN. RUN wraps its counter at the end of each period. The output is high only in RUN, only for counts below the high time, and only while hold is clear.

Top module: `pwm_bank`

## Requirements
- R1: After reset the control word (0x10) reads 0x1 (hold set). All staged channel words read 0, and every output is low.
- R2: The version (0x00), identity (0x04) and signature (0x0C) words read their parameter values. The channel-count word (0x14) reads the number of channels. Writes to any of these four words have no effect.
- R3: The scratch word (0x08) reads back exactly the last value written to it, for example 0x5A0F0081.
- R4: While control bit 0 (hold) is 1, every output is low and every channel is held in HALT. After hold is cleared, a channel's first high cycle comes offset+2 cycles after the edge that clears it.
- R5: Writing control bit 1 copies every staged word into the working set on the same edge. Staged words have no effect on the outputs until then. Bit 1 always reads back 0.
- R6: Channel n has its period word at 0x40+12n, its high-time word at 0x44+12n and its start-delay word at 0x48+12n. Each word reads back the last value written to it.
- R7: In RUN with period P>0 and high time D<P, the output is high for the first D cycles of every P-cycle period and low for the other P-D cycles.
- R8: If D is greater than or equal to P (with P>0), the output stays high through every RUN cycle.
- R9: A working period of 0 keeps the output low.
- R10: A commit while hold is clear restarts every channel. Its output stays low for offset+1 cycles after the commit edge, and then its first period begins.
- R11: Reads of addresses outside the map (for example 0x18, 0x3C, 0x70) return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_addr | input | ADDR_W | Byte address of the write |
| bus_wr_data | input | CNT_W | Write data |
| bus_rd_addr | input | ADDR_W | Byte address of the read |
| bus_rd_data | output | CNT_W | Read data, combinational from bus_rd_addr |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
All four channels run at once, each with a different setting. One channel has a plain duty below its period, one has a duty above its period, one has a zero period and one has a non-zero start delay. A per-cycle comparison against a reference waveform therefore separates wrap, saturation, disable and delay faults from one another. The same comparison runs after the hold is released and again after a commit while the channels are running, so the two restart latencies are told apart. It also runs after staged writes with no commit, which shows whether a staged value leaks into the working set before the strobe.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;

    localparam int CNT_W = 32;

    // global word offsets
    localparam int OFS_VERSION = 'h00;
    localparam int OFS_IDENT   = 'h04;
    localparam int OFS_SCRATCH = 'h08;
    localparam int OFS_MAGIC   = 'h0C;
    localparam int OFS_CTRL    = 'h10;
    localparam int OFS_COUNT   = 'h14;

    // per-channel groups
    localparam int CH_BASE   = 'h40;
    localparam int CH_STRIDE = 12;
    localparam int FLD_PERIOD = 0;
    localparam int FLD_HIGH   = 4;
    localparam int FLD_DELAY  = 8;

    // control bits
    localparam int CTRL_HOLD_BIT   = 0;
    localparam int CTRL_COMMIT_BIT = 1;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] delay;
    } ch_cfg_t;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ch_state_t;

    function automatic int ch_word(input int ch, input int fld);
        return CH_BASE + CH_STRIDE * ch + fld;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
`timescale 1ns/1ps
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int               NUM_CH  = 4,
    parameter int               ADDR_W  = 8,
    parameter logic [CNT_W-1:0] VERSION = 32'h0002_0100,
    parameter logic [CNT_W-1:0] IDENT   = 32'h0000_0000,
    parameter logic [CNT_W-1:0] MAGIC   = 32'h7057_6D31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [CNT_W-1:0]         rd_data,
    output logic                     hold_o,
    output logic                     commit_o,
    output ch_cfg_t [NUM_CH-1:0]     active_o
);

    localparam logic [ADDR_W-1:0] A_VERSION = ADDR_W'(OFS_VERSION);
    localparam logic [ADDR_W-1:0] A_IDENT   = ADDR_W'(OFS_IDENT);
    localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(OFS_SCRATCH);
    localparam logic [ADDR_W-1:0] A_MAGIC   = ADDR_W'(OFS_MAGIC);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(OFS_COUNT);

    logic [CNT_W-1:0]    scratch_q;
    logic                hold_q;
    ch_cfg_t [NUM_CH-1:0] shadow_q;
    ch_cfg_t [NUM_CH-1:0] active_q;

    // commit acts on the edge that accepts the control write
    assign commit_o = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_COMMIT_BIT];
    assign hold_o   = hold_q;
    assign active_o = active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q <= '0;
            hold_q    <= 1'b1;
            shadow_q  <= '0;
            active_q  <= '0;
        end else begin
            if (wr_en) begin
                if (wr_addr == A_SCRATCH) scratch_q <= wr_data;
                if (wr_addr == A_CTRL)    hold_q    <= wr_data[CTRL_HOLD_BIT];
                for (int c = 0; c < NUM_CH; c++) begin
                    if (wr_addr == ADDR_W'(ch_word(c, FLD_PERIOD))) shadow_q[c].period <= wr_data;
                    if (wr_addr == ADDR_W'(ch_word(c, FLD_HIGH)))   shadow_q[c].high   <= wr_data;
                    if (wr_addr == ADDR_W'(ch_word(c, FLD_DELAY)))  shadow_q[c].delay  <= wr_data;
                end
            end
            if (commit_o) active_q <= shadow_q;
        end
    end

    always_comb begin
        case (rd_addr)
            A_VERSION: rd_data = VERSION;
            A_IDENT:   rd_data = IDENT;
            A_SCRATCH: rd_data = scratch_q;
            A_MAGIC:   rd_data = MAGIC;
            A_CTRL:    rd_data = CNT_W'(hold_q);
            A_COUNT:   rd_data = CNT_W'(NUM_CH);
            default:   rd_data = '0;
        endcase
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(ch_word(c, FLD_PERIOD))) rd_data = shadow_q[c].period;
            if (rd_addr == ADDR_W'(ch_word(c, FLD_HIGH)))   rd_data = shadow_q[c].high;
            if (rd_addr == ADDR_W'(ch_word(c, FLD_DELAY)))  rd_data = shadow_q[c].delay;
        end
    end

    AST_COMMIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_CTRL) |-> (rd_data[CTRL_COMMIT_BIT] == 1'b0)); // R5

    AST_SCRATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SCRATCH) |=> (scratch_q == $past(wr_data))); // R3

    for (genvar g = 0; g < NUM_CH; g++) begin : g_commit_chk
        AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
            commit_o |=> (active_q[g] == $past(shadow_q[g]))); // R5
        AST_NO_COMMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !commit_o |=> $stable(active_q[g])); // R5
    end

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hold_i,
    input  logic    restart_i,
    input  ch_cfg_t cfg_i,
    output logic    pwm_o
);

    ch_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             end_of_period;

    assign end_of_period = (cfg_i.period == '0) || (cnt_q >= cfg_i.period - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_HALT: begin
                cnt_d = '0;
                if (!hold_i) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (cnt_q >= cfg_i.delay) begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                cnt_d = end_of_period ? '0 : cnt_q + 1'b1;
            end
            default: begin
                st_d  = ST_HALT;
                cnt_d = '0;
            end
        endcase
        if (restart_i) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
        end
        if (hold_i) begin
            st_d  = ST_HALT;
            cnt_d = '0;
        end
    end

    // output
    always_comb begin
        pwm_o = 1'b0;
        if (!hold_i && st_q == ST_RUN && cfg_i.period != '0)
            pwm_o = (cnt_q < cfg_i.high);
    end

    AST_HOLD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q == ST_HALT && cnt_q == '0)); // R4

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && cfg_i.period != '0) |-> (cnt_q < cfg_i.period)); // R7

    AST_RESTART_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !hold_i) |=> (st_q == ST_WAIT && cnt_q == '0)); // R10

endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int               NUM_CH  = 4,
    parameter int               ADDR_W  = 8,
    parameter logic [CNT_W-1:0] VERSION = 32'h0002_0100,
    parameter logic [CNT_W-1:0] IDENT   = 32'h0000_0000,
    parameter logic [CNT_W-1:0] MAGIC   = 32'h7057_6D31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_wr_addr,
    input  logic [CNT_W-1:0]  bus_wr_data,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [CNT_W-1:0]  bus_rd_data,
    output logic [NUM_CH-1:0] pwm_out
);

    logic                 hold;
    logic                 commit;
    ch_cfg_t [NUM_CH-1:0] active;

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .VERSION(VERSION),
        .IDENT  (IDENT),
        .MAGIC  (MAGIC)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_addr (bus_wr_addr),
        .wr_data (bus_wr_data),
        .rd_addr (bus_rd_addr),
        .rd_data (bus_rd_data),
        .hold_o  (hold),
        .commit_o(commit),
        .active_o(active)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_i   (hold),
            .restart_i(commit),
            .cfg_i    (active[g]),
            .pwm_o    (pwm_out[g])
        );

        AST_ZERO_PERIOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (active[g].period == '0) |-> !pwm_out[g]); // R9

        AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            hold |-> !pwm_out[g]); // R4

        AST_FULL_HIGH_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
            (!hold && active[g].period != '0 && active[g].high >= active[g].period
             && !$past(commit) && $past(pwm_out[g])) |-> pwm_out[g]); // R8
    end

endmodule

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm;

    int     errs = 0;
    int     checks = 0;
    longint cyc = 0;
    longint base = 0;
    int     P[NCH];
    int     D[NCH];
    int     O[NCH];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_bank dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(wr_en), .bus_wr_addr(wr_addr), .bus_wr_data(wr_data),
        .bus_rd_addr(rd_addr), .bus_rd_data(rd_data),
        .pwm_out(pwm)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    function automatic bit exp_bit(input int ch, input longint k);
        longint j;
        if (P[ch] == 0) return 1'b0;
        if (k <= O[ch]) return 1'b0;
        j = (k - O[ch] - 1) % P[ch];
        return j < D[ch];
    endfunction

    task automatic check_wave(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < NCH; c++)
                chk(pwm[c] == exp_bit(c, cyc - base), req, pwm[c], exp_bit(c, cyc - base));
            @(negedge clk);
        end
    endtask

    task automatic check_low(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(pwm == 4'b0, req, pwm, 0);
            @(negedge clk);
        end
    endtask

    task automatic stage(input int c, input int p, input int d, input int o);
        wr(8'(8'h40 + 12 * c), p);
        wr(8'(8'h44 + 12 * c), d);
        wr(8'(8'h48 + 12 * c), o);
    endtask

    task automatic t_reset();
        rd_chk(8'h10, 32'h1, "R1 control");
        for (int c = 0; c < NCH; c++) rd_chk(8'(8'h40 + 12 * c), 0, "R1 staged");
        check_low(4, "R1 outputs");
    endtask

    task automatic t_ident();
        rd_chk(8'h00, 32'h0002_0100, "R2 version");
        rd_chk(8'h04, 32'h0, "R2 ident");
        rd_chk(8'h0C, 32'h7057_6D31, "R2 magic");
        rd_chk(8'h14, NCH, "R2 count");
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'h1234); wr(8'h0C, 0); wr(8'h14, 9);
        rd_chk(8'h00, 32'h0002_0100, "R2 version ro");
        rd_chk(8'h04, 32'h0, "R2 ident ro");
        rd_chk(8'h0C, 32'h7057_6D31, "R2 magic ro");
        rd_chk(8'h14, NCH, "R2 count ro");
    endtask

    task automatic t_scratch();
        wr(8'h08, 32'h5A0F_0081);
        rd_chk(8'h08, 32'h5A0F_0081, "R3 pattern");
        wr(8'h08, 32'hA5F0_FF7E);
        rd_chk(8'h08, 32'hA5F0_FF7E, "R3 inverse");
    endtask

    task automatic t_unmapped();
        wr(8'h18, 32'hDEAD_BEEF); wr(8'h3C, 32'h1111); wr(8'h70, 32'h2222);
        rd_chk(8'h18, 0, "R11 0x18");
        rd_chk(8'h3C, 0, "R11 0x3C");
        rd_chk(8'h70, 0, "R11 0x70");
        rd_chk(8'h08, 32'hA5F0_FF7E, "R11 scratch untouched");
        rd_chk(8'h10, 32'h1, "R11 control untouched");
    endtask

    task automatic t_map();
        for (int c = 0; c < NCH; c++) stage(c, 32'h100 + c, 32'h200 + c, 32'h300 + c);
        for (int c = 0; c < NCH; c++) begin
            rd_chk(8'(8'h40 + 12 * c), 32'h100 + c, "R6 period");
            rd_chk(8'(8'h44 + 12 * c), 32'h200 + c, "R6 high");
            rd_chk(8'(8'h48 + 12 * c), 32'h300 + c, "R6 delay");
        end
        check_low(3, "R5 staged no effect while held");
    endtask

    task automatic t_start();
        P = '{8, 5, 0, 6}; D = '{3, 7, 4, 2}; O = '{0, 0, 0, 4};
        for (int c = 0; c < NCH; c++) stage(c, P[c], D[c], O[c]);
        wr(8'h10, 32'h3);
        rd_chk(8'h10, 32'h1, "R5 commit bit reads zero");
        check_low(10, "R4 held after commit");
        wr(8'h10, 32'h0);
        base = cyc;
        for (int c = 0; c < NCH; c++) O[c] = O[c] + 1;
        check_wave(48, "R4 R7 R8 R9 release");
    endtask

    task automatic t_staged();
        wr(8'h40, 4); wr(8'h44, 1); wr(8'h48, 0);
        check_wave(20, "R5 staged ignored");
        rd_chk(8'h10, 32'h0, "R5 control");
        wr(8'h10, 32'h2);
        base = cyc;
        P[0] = 4; D[0] = 1; O = '{0, 0, 0, 4};
        check_wave(40, "R10 R7 commit restart");
    endtask

    task automatic t_hold();
        wr(8'h10, 32'h1);
        check_low(20, "R4 hold");
        wr(8'h10, 32'h0);
        base = cyc;
        for (int c = 0; c < NCH; c++) O[c] = O[c] + 1;
        check_wave(30, "R4 re-release");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_scratch();
        t_unmapped();
        t_map();
        t_start();
        t_staged();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #400000;
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule